// File: doc/BRIEF.md
# Bit-Test-and-Skip Execution Unit

This unit carries out the two conditional-skip instructions of an 8-bit microcontroller core. One variant skips the following instruction when a selected bit of a data-memory byte is zero. The other skips it when that bit is one. The unit accepts a 16-bit instruction word from the decode stage and forms a 12-bit data-memory address. It reads the byte through a single read port into the register file, then tests the chosen bit.

Every machine cycle has four phases, and each phase takes one clock. Phase 1 decodes, phase 2 reads, phase 3 evaluates and phase 4 is idle. When the skip is taken, the unit runs one or two further machine cycles in which nothing is done. The count depends on whether the fetch stage reports the next instruction as one or two words long. At the end it reports how many prefetched words the fetch stage must discard, the total machine-cycle count and the next program counter. The unit never writes any data or status.

Top module: `bit_skip_unit`

## Requirements
- R1: An instruction is accepted only when `start` is high, the unit is idle, and `instr[15:13]` is `101`. Bit 12 selects the variant: 1 means skip-if-clear and 0 means skip-if-set. `instr[11:9]` is the bit number, `instr[8]` is the access selector and `instr[7:0]` is the file address `f`. Any other word is ignored: `busy` and `done` stay low.
- R2: With access selector 1, the read address is `{bank_sel, f}`.
- R3: With access selector 0 and indexed mode not applicable, an `f` below 0x60 reads address `0x000 + f`. An `f` of 0x60 or above reads `0xF00 + f`.
- R4: With access selector 0, `ext_mode` high and `f` at most 0x5F, the read address is `(idx_base + f) mod 4096`.
- R5: After the accepting clock edge, `busy` rises and `phase` counts 0,1,2,3 once per clock. `rf_rd` is high for exactly one clock, in phase 1 of the first machine cycle.
- R6: The skip is taken when the tested bit is 0 for skip-if-clear, or 1 for skip-if-set. With no skip, `done` rises 4 clocks after the accepting edge, with `flush_cnt` = 0 and `cycles` = 1.
- R7: With a skip, `flush_cnt` is 1 and `cycles` is 2 after 8 clocks if `next_two_word` is 0. It is 2 and 3 after 12 clocks if `next_two_word` is 1. `nop_slot` is high during the discarded cycles only.
- R8: `pc_next` = `(pc_in + 2*(1 + flush_cnt)) mod 2^PC_W`.
- R9: A `start` pulse while `busy` is high has no effect on the running instruction or its results.
- R10: `done` is high for one clock. Results hold until the next accepted instruction. After reset, `busy`, `done`, `flush_cnt`, `cycles` and `pc_next` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction word offered |
| instr | input | 16 | Instruction word |
| next_two_word | input | 1 | Following instruction is two words long |
| ext_mode | input | 1 | Extended instruction mode enabled |
| bank_sel | input | BANK_W | Bank-select register value |
| idx_base | input | AW | Pointer used for indexed addressing |
| pc_in | input | PC_W | Address of this instruction |
| rf_rdata | input | 8 | Register-file read data |
| rf_rd | output | 1 | Register-file read strobe |
| rf_addr | output | AW | Register-file read address |
| busy | output | 1 | Instruction in progress |
| phase | output | 2 | Current phase, 0..3 |
| nop_slot | output | 1 | Discarded machine cycle in progress |
| done | output | 1 | Result pulse |
| flush_cnt | output | 2 | Prefetched words to discard |
| cycles | output | 2 | Machine cycles used |
| pc_next | output | PC_W | Next program counter |

## Verification
Random instruction words cover both variants, every bit number, both access selectors, the extended mode and random register contents. Each of these stimuli separates the three address sources and the two skip polarities. Directed cases place `f` on either side of the 0x5F/0x60 split, with and without extended mode, to catch an off-by-one in the window test. They also make the indexed sum wrap past 0xFFF and make the program counter wrap. A skip before a two-word instruction is compared with a skip before a one-word instruction to check both the done timing and the flush count. Some cases inject a second `start` mid-instruction, and foreign opcodes show that non-matching words are ignored.

// File: rtl/bit_skip_unit.sv
module bit_skip_unit #(
  parameter int PC_W   = 21,
  parameter int BANK_W = 4,
  parameter logic [7:0] SPLIT = 8'h60,
  localparam int AW    = BANK_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       instr,
  input  logic              next_two_word,
  input  logic              ext_mode,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [AW-1:0]     idx_base,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [7:0]        rf_rdata,
  output logic              rf_rd,
  output logic [AW-1:0]     rf_addr,
  output logic              busy,
  output logic [1:0]        phase,
  output logic              nop_slot,
  output logic              done,
  output logic [1:0]        flush_cnt,
  output logic [1:0]        cycles,
  output logic [PC_W-1:0]   pc_next
);

  logic [15:0]       ir;
  logic              nx2, ext;
  logic [BANK_W-1:0] bsel;
  logic [AW-1:0]     base;
  logic [PC_W-1:0]   pc_q;
  logic [1:0]        mcyc;
  logic              skip;

  wire       hit    = instr[15:13] == 3'b101;
  wire       accept = start && !busy && hit;
  wire [2:0] bnum   = ir[11:9];
  wire       acc    = ir[8];
  wire [7:0] f      = ir[7:0];

  always_comb begin
    if (acc)                 rf_addr = {bsel, f};
    else if (ext && f < SPLIT) rf_addr = base + AW'(f);
    else if (f < SPLIT)      rf_addr = {{BANK_W{1'b0}}, f};
    else                     rf_addr = {{BANK_W{1'b1}}, f};
  end

  wire last = (mcyc == 2'd0 && !skip) || (mcyc == 2'd1 && !nx2) || (mcyc == 2'd2);

  assign rf_rd    = busy && phase == 2'd1 && mcyc == 2'd0;
  assign nop_slot = busy && mcyc != 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir <= '0; nx2 <= 1'b0; ext <= 1'b0; bsel <= '0; base <= '0; pc_q <= '0;
      busy <= 1'b0; phase <= 2'd0; mcyc <= 2'd0; skip <= 1'b0;
      done <= 1'b0; flush_cnt <= 2'd0; cycles <= 2'd0; pc_next <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        ir <= instr; nx2 <= next_two_word; ext <= ext_mode;
        bsel <= bank_sel; base <= idx_base; pc_q <= pc_in;
        busy <= 1'b1; phase <= 2'd0; mcyc <= 2'd0; skip <= 1'b0;
      end else if (busy) begin
        phase <= phase + 2'd1;
        if (rf_rd) skip <= rf_rdata[bnum] ^ ir[12];
        if (phase == 2'd3) begin
          if (last) begin
            busy      <= 1'b0;
            done      <= 1'b1;
            flush_cnt <= mcyc;
            cycles    <= mcyc + 2'd1;
            pc_next   <= pc_q + PC_W'({mcyc + 2'd1, 1'b0});
          end else begin
            mcyc <= mcyc + 2'd1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/bit_skip_unit_chk.sv
module bit_skip_unit_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rf_rd,
  input logic [AW-1:0] rf_addr,
  input logic          busy,
  input logic [1:0]    phase,
  input logic          nop_slot,
  input logic          done,
  input logic [1:0]    flush_cnt,
  input logic [1:0]    cycles
);

  a_r5_read_slot: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd |-> (phase == 2'd1 && !nop_slot && busy));

  a_r5_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(rst_n)) |-> phase == 2'($past(phase) + 2'd1));

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(rst_n)) |-> $stable(rf_addr));

  a_r7_cycle_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles == flush_cnt + 2'd1 && flush_cnt <= 2'd2));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind bit_skip_unit bit_skip_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rf_rd(rf_rd), .rf_addr(rf_addr), .busy(busy),
  .phase(phase), .nop_slot(nop_slot), .done(done), .flush_cnt(flush_cnt),
  .cycles(cycles)
);

// File: tb/sim_bit_skip_unit.sv
module sim_bit_skip_unit;
  localparam int PC_W = 21;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] instr = '0;
  logic next_two_word = 1'b0, ext_mode = 1'b0;
  logic [3:0] bank_sel = '0;
  logic [11:0] idx_base = '0;
  logic [PC_W-1:0] pc_in = '0;
  logic [7:0] rf_rdata, key = '0;
  logic rf_rd, busy, nop_slot, done;
  logic [11:0] rf_addr;
  logic [1:0] phase, flush_cnt, cycles;
  logic [PC_W-1:0] pc_next;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign rf_rdata = key ^ rf_addr[7:0] ^ {rf_addr[11:8], rf_addr[11:8]};

  bit_skip_unit #(.PC_W(PC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .next_two_word(next_two_word), .ext_mode(ext_mode), .bank_sel(bank_sel),
    .idx_base(idx_base), .pc_in(pc_in), .rf_rdata(rf_rdata), .rf_rd(rf_rd),
    .rf_addr(rf_addr), .busy(busy), .phase(phase), .nop_slot(nop_slot),
    .done(done), .flush_cnt(flush_cnt), .cycles(cycles), .pc_next(pc_next)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_addr(input logic [15:0] w, input logic e,
                                           input logic [3:0] bs, input logic [11:0] ib);
    logic [7:0] f = w[7:0];
    if (w[8]) return {bs, f};
    if (e && f <= 8'h5F) return ib + {4'h0, f};
    if (f <= 8'h5F) return {4'h0, f};
    return {4'hF, f};
  endfunction

  function automatic int exp_flush(input logic [15:0] w, input logic [11:0] a,
                                   input logic [7:0] k, input logic n2);
    logic [7:0] d = k ^ a[7:0] ^ {a[11:8], a[11:8]};
    logic bitv = d[w[11:9]];
    logic sk = w[12] ? !bitv : bitv;
    if (!sk) return 0;
    return n2 ? 2 : 1;
  endfunction

  task automatic run_case(input logic [15:0] w, input logic n2, input logic e,
                          input logic [3:0] bs, input logic [11:0] ib,
                          input logic [PC_W-1:0] pc, input logic [7:0] k, input bit intrude);
    logic [11:0] ea = exp_addr(w, e, bs, ib);
    int fl = exp_flush(w, ea, k, n2);
    string atag = w[8] ? "R2" : ((e && w[7:0] <= 8'h5F) ? "R4" : "R3");
    int kk = 0, rdc = 0;
    logic [PC_W-1:0] pexp = pc + PC_W'(2 * (1 + fl));
    @(negedge clk);
    instr = w; next_two_word = n2; ext_mode = e; bank_sel = bs;
    idx_base = ib; pc_in = pc; key = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R5 busy", busy, 1);
    chk("R5 phase0", phase, 0);
    while (!done && kk < 20) begin
      @(negedge clk);
      kk++;
      if (rf_rd) rdc++;
      if (kk == 1) begin
        chk("R5 rd", rf_rd, 1);
        chk(atag, rf_addr, ea);
      end
      if (kk == 2) begin
        chk("R7 nop early", nop_slot, 0);
        if (intrude) begin
          start = 1'b1; instr = {3'b101, ~w[12], w[11:0] ^ 12'hFFF};
          next_two_word = ~n2; pc_in = ~pc;
        end
      end
      if (kk == 3 && intrude) begin
        start = 1'b0; instr = w; next_two_word = n2; pc_in = pc;
      end
      if (kk == 5 && fl > 0) chk("R7 nop", nop_slot, 1);
    end
    chk(fl == 0 ? "R6 time" : "R7 time", kk, 4 * (1 + fl));
    chk(intrude ? "R9 flush" : (fl == 0 ? "R6 flush" : "R7 flush"), flush_cnt, fl);
    chk("R7 cycles", cycles, fl + 1);
    chk("R8 pc", pc_next, pexp);
    chk("R5 reads", rdc, 1);
    @(negedge clk);
    chk("R10 pulse", done, 0);
    chk("R10 hold", pc_next, pexp);
  endtask

  task automatic run_foreign(input logic [15:0] w);
    logic [1:0] fh = flush_cnt;
    logic [PC_W-1:0] ph = pc_next;
    @(negedge clk);
    instr = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (busy || done) break;
    end
    chk("R1 ignored busy", busy, 0);
    chk("R1 ignored done", done, 0);
    chk("R10 hold flush", flush_cnt, fh);
    chk("R10 hold pc", pc_next, ph);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R10 rst busy", busy, 0);
    chk("R10 rst done", done, 0);
    chk("R10 rst flush", flush_cnt, 0);
    chk("R10 rst cycles", cycles, 0);
    chk("R10 rst pc", pc_next, 0);
    chk("R5 rst rd", rf_rd, 0);
    // directed corners; key chosen per case
    run_case(16'hB5A3, 1'b0, 1'b0, 4'h7, 12'h000, 21'h000100, 8'h00, 0);
    run_case(16'hA05F, 1'b0, 1'b0, 4'h0, 12'h000, 21'h000200, 8'hFF, 0);
    run_case(16'hA060, 1'b1, 1'b0, 4'h0, 12'h000, 21'h000300, 8'hFF, 0);
    run_case(16'hB05F, 1'b1, 1'b1, 4'h3, 12'hFF0, 21'h1FFFFE, 8'h00, 0);
    run_case(16'hB060, 1'b0, 1'b1, 4'h3, 12'h123, 21'h000400, 8'h00, 0);
    run_case(16'hA000, 1'b1, 1'b1, 4'h3, 12'h800, 21'h000500, 8'h00, 1);
    run_foreign(16'h9234);
    run_foreign(16'hC5A3);
    for (int i = 0; i < 400; i++) begin
      logic [15:0] w = {3'b101, 13'($urandom)};
      run_case(w, 1'($urandom), 1'($urandom), 4'($urandom), 12'($urandom),
               PC_W'($urandom) & ~PC_W'(1), 8'($urandom), ($urandom % 5) == 0);
      if (i % 50 == 0) run_foreign(16'($urandom) & 16'h9FFF);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule